// File: doc/BRIEF.md
# Switch Reset Control Register

This block is one 32-bit control register on a simple configuration bus. Software uses it to request a whole-device (fundamental) reset or a hot reset. The write is acknowledged first, and the reset pulse comes out only after a programmable delay, 1 ms at the core clock by default. A hot-reset request also asks the upstream PHY for a full link retrain.

The register also holds several sticky control flags:
- A reset-halt flag keeps the core logic in reset after a reset operation until software releases it.
- An unlock flag qualifies writes to lockable registers across the device. This register holds one of them: a power-budget unlock flag that opens the per-port power-budget data registers to writes.
- A mask flag blocks the hot reset that a link-down event of the upstream data-link layer would otherwise raise.

Top module: `sw_reset_ctrl`

## Requirements
- R1: Only an access to address REG_ADDR (default 0x404) is decoded. It returns `ack` high for one cycle after the cycle in which `wrEn` or `rdEn` was sampled, with read data valid in that cycle. An access to any other address gets no ack and changes nothing.
- R2: The read value has the layout bit 2 halt flag, bit 3 unlock flag, bit 4 power-budget unlock, bit 5 link-down hot-reset mask. Bits 0, 1 and 31:6 read as zero, and writes to bits 31:6 are ignored.
- R3: Writing a one to bit 0 makes `fundRstPulse` high for exactly one cycle, in the cycle after the DELAY_CYCLES-th rising edge following the write edge. The ack always comes first. Writing zero to bit 0 does nothing.
- R4: Writing a one to bit 1 makes `hotRstPulse` and `phyRetrainReq` high together for one cycle, with the same delay as R3.
- R5: At most one reset can be pending. A fundamental request replaces a pending hot request, and only the fundamental pulse then appears. A hot request made while any reset is pending is dropped. A request written in the same cycle as bit 0 and bit 1 counts as fundamental.
- R6: While `porRstN` is low at a clock edge, the flags take these values: unlock 1, power-budget unlock 0, link-down mask 0, and the halt flag loaded from `rstHaltPin`.
- R7: `coreHoldReset` is loaded from `rstHaltPin` during `porRstN` and drops when software writes a zero to bit 2. A later software write of a one to bit 2 is stored and reads back, but does not raise `coreHoldReset`.
- R8: Bit 4 changes on a write only if the unlock flag was set before that write. `rwlWriteEnable` reflects the unlock flag.
- R9: `pwrBudgetWriteEnable` reflects bit 4.
- R10: A cycle with `hotRstIn` high forces the unlock flag to one and leaves bits 2, 4 and 5 unchanged.
- R11: `linkDownHotRst` follows `linkDownEvt` while bit 5 is zero and stays low while bit 5 is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porRstN | input | 1 | Fundamental / power-on reset, active low, sampled synchronously |
| hotRstIn | input | 1 | High while a hot reset operation is applied to the device |
| rstHaltPin | input | 1 | Reset-halt request, sampled during `porRstN` |
| linkDownEvt | input | 1 | Upstream data-link layer entered the link-down state |
| addr | input | 12 | Register bus address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid with `ack`, zero otherwise |
| ack | output | 1 | One-cycle access completion |
| fundRstPulse | output | 1 | Delayed fundamental-reset pulse |
| hotRstPulse | output | 1 | Delayed hot-reset pulse |
| phyRetrainReq | output | 1 | Full link retrain request, paired with the hot-reset pulse |
| coreHoldReset | output | 1 | Holds the core logic (not the SMBus domain) in reset |
| rwlWriteEnable | output | 1 | Write qualifier for lockable fields device-wide |
| pwrBudgetWriteEnable | output | 1 | Write qualifier for the per-port power-budget data registers |
| linkDownHotRst | output | 1 | Hot reset raised by a link-down event, unless masked |

## Verification
A wrong pending-state or counter value shows up as a reset pulse that arrives early or late, as two pulses, or as a hot pulse where a fundamental pulse should have replaced it. The bench times pulses to the exact cycle and counts them over a full delay window. A wrong flag value shows up at the next read one cycle later, and immediately on the qualifier outputs. That includes a lockable bit written while locked, a sticky bit lost on a hot reset, or a halt hold raised again by software.

// File: rtl/sw_rst_pkg.sv
package sw_rst_pkg;
  localparam int FUND_BIT   = 0;
  localparam int HOT_BIT    = 1;
  localparam int HALT_BIT   = 2;
  localparam int UNLOCK_BIT = 3;
  localparam int PWRB_BIT   = 4;
  localparam int LDMASK_BIT = 5;
  localparam int USED_BITS  = 6;

  // strobes from the control half to the register half
  typedef struct packed {
    logic regWr;
    logic regRd;
    logic fundFire;
    logic hotFire;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    PEND_IDLE = 2'd0,
    PEND_FUND = 2'd1,
    PEND_HOT  = 2'd2
  } pendState_t;
endpackage

// File: rtl/sw_rst_ctl.sv
module sw_rst_ctl
  import sw_rst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h404,
  parameter int DELAY_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic              ack,
  output ctlStrobe_t        strobe,
  output logic              fundRstPulse,
  output logic              hotRstPulse,
  output logic              phyRetrainReq
);
  localparam int CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYCLES - 1);

  logic hit, wrHit, rdHit;
  logic fundReq, hotReq;
  pendState_t pendState, pendNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic fireFund, fireHot;

  assign hit     = (addr == REG_ADDR);
  assign wrHit   = wrEn && hit;
  assign rdHit   = rdEn && hit && !wrEn;
  assign fundReq = wrHit && wrData[FUND_BIT];
  assign hotReq  = wrHit && wrData[HOT_BIT];

  always_comb begin
    pendNext = pendState;
    cntNext  = cnt;
    fireFund = 1'b0;
    fireHot  = 1'b0;
    if (pendState != PEND_IDLE) begin
      if (cnt == '0) begin
        fireFund = (pendState == PEND_FUND);
        fireHot  = (pendState == PEND_HOT);
        pendNext = PEND_IDLE;
      end else begin
        cntNext = cnt - 1'b1;
      end
    end
    if (fundReq && pendState != PEND_FUND) begin
      pendNext = PEND_FUND;
      cntNext  = CNT_LOAD;
      fireHot  = 1'b0;
    end else if (hotReq && !fundReq && pendState == PEND_IDLE) begin
      pendNext = PEND_HOT;
      cntNext  = CNT_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      pendState     <= PEND_IDLE;
      cnt           <= '0;
      ack           <= 1'b0;
      fundRstPulse  <= 1'b0;
      hotRstPulse   <= 1'b0;
      phyRetrainReq <= 1'b0;
    end else begin
      pendState     <= pendNext;
      cnt           <= cntNext;
      ack           <= wrHit || rdHit;
      fundRstPulse  <= fireFund;
      hotRstPulse   <= fireHot;
      phyRetrainReq <= fireHot;
    end
  end

  always_comb begin
    strobe.regWr    = wrHit;
    strobe.regRd    = rdHit;
    strobe.fundFire = fireFund;
    strobe.hotFire  = fireHot;
  end
endmodule

// File: rtl/sw_rst_regs.sv
module sw_rst_regs
  import sw_rst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              hotRstIn,
  input  logic              rstHaltPin,
  input  logic              linkDownEvt,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              coreHoldReset,
  output logic              rwlWriteEnable,
  output logic              pwrBudgetWriteEnable,
  output logic              linkDownHotRst
);
  logic haltBit, unlockBit, pwrbBit, ldMaskBit, holdActive;
  logic [DATA_W-1:0] readVal;

  // place each flag at its bit; every other position reads zero
  always_comb begin
    readVal = '0;
    readVal[HALT_BIT]   = haltBit;
    readVal[UNLOCK_BIT] = unlockBit;
    readVal[PWRB_BIT]   = pwrbBit;
    readVal[LDMASK_BIT] = ldMaskBit;
  end

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      haltBit    <= rstHaltPin;
      holdActive <= rstHaltPin;
      unlockBit  <= 1'b1;
      pwrbBit    <= 1'b0;
      ldMaskBit  <= 1'b0;
      rdData     <= '0;
    end else begin
      rdData <= strobe.regRd ? readVal : '0;
      if (strobe.regWr) begin
        haltBit   <= wrData[HALT_BIT];
        ldMaskBit <= wrData[LDMASK_BIT];
        if (unlockBit) pwrbBit <= wrData[PWRB_BIT];
        if (!wrData[HALT_BIT]) holdActive <= 1'b0;
      end
      if (hotRstIn) unlockBit <= 1'b1;
      else if (strobe.regWr) unlockBit <= wrData[UNLOCK_BIT];
    end
  end

  assign coreHoldReset        = holdActive;
  assign rwlWriteEnable       = unlockBit;
  assign pwrBudgetWriteEnable = pwrbBit;
  assign linkDownHotRst       = linkDownEvt && !ldMaskBit;
endmodule

// File: rtl/sw_reset_ctrl.sv
module sw_reset_ctrl
  import sw_rst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h404,
  parameter int DELAY_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              hotRstIn,
  input  logic              rstHaltPin,
  input  logic              linkDownEvt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              ack,
  output logic              fundRstPulse,
  output logic              hotRstPulse,
  output logic              phyRetrainReq,
  output logic              coreHoldReset,
  output logic              rwlWriteEnable,
  output logic              pwrBudgetWriteEnable,
  output logic              linkDownHotRst
);
  ctlStrobe_t strobe;

  sw_rst_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .DELAY_CYCLES(DELAY_CYCLES)
  ) ctl (
    .clk(clk), .porRstN(porRstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .ack(ack), .strobe(strobe), .fundRstPulse(fundRstPulse),
    .hotRstPulse(hotRstPulse), .phyRetrainReq(phyRetrainReq)
  );

  sw_rst_regs #(.DATA_W(DATA_W)) regs (
    .clk(clk), .porRstN(porRstN), .hotRstIn(hotRstIn), .rstHaltPin(rstHaltPin),
    .linkDownEvt(linkDownEvt), .strobe(strobe), .wrData(wrData), .rdData(rdData),
    .coreHoldReset(coreHoldReset), .rwlWriteEnable(rwlWriteEnable),
    .pwrBudgetWriteEnable(pwrBudgetWriteEnable), .linkDownHotRst(linkDownHotRst)
  );
endmodule

// File: rtl/sw_reset_ctrl_chk.sv
module sw_reset_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              porRstN,
  input logic              hotRstIn,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              ack,
  input logic              fundRstPulse,
  input logic              hotRstPulse,
  input logic              phyRetrainReq,
  input logic              coreHoldReset,
  input logic              rwlWriteEnable
);
  // R1
  ack_source_chk: assert property (@(posedge clk) disable iff (!porRstN)
    ack |-> $past(wrEn || rdEn));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (rdData[DATA_W-1:6] == '0) && (rdData[1:0] == 2'b00));
  // R3
  fund_one_cycle_chk: assert property (@(posedge clk) disable iff (!porRstN)
    fundRstPulse |=> !fundRstPulse);
  // R4
  hot_phy_pair_chk: assert property (@(posedge clk) disable iff (!porRstN)
    hotRstPulse |-> phyRetrainReq);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !(fundRstPulse && hotRstPulse));
  // R7
  hold_rise_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(coreHoldReset) |-> $past(!porRstN));
  // R10
  hot_unlock_chk: assert property (@(posedge clk) disable iff (!porRstN)
    hotRstIn |=> rwlWriteEnable);
endmodule

bind sw_reset_ctrl sw_reset_ctrl_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .porRstN(porRstN), .hotRstIn(hotRstIn), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .ack(ack), .fundRstPulse(fundRstPulse), .hotRstPulse(hotRstPulse),
  .phyRetrainReq(phyRetrainReq), .coreHoldReset(coreHoldReset),
  .rwlWriteEnable(rwlWriteEnable)
);

// File: tb/sw_reset_ctrl_test.sv
`timescale 1ns/1ps
module sw_reset_ctrl_test;
  localparam int D = 16;
  localparam logic [11:0] REG = 12'h404;

  logic clk = 1'b0;
  logic porRstN = 1'b0, hotRstIn = 1'b0, rstHaltPin = 1'b0, linkDownEvt = 1'b0;
  logic [11:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic ack, fundRstPulse, hotRstPulse, phyRetrainReq, coreHoldReset;
  logic rwlWriteEnable, pwrBudgetWriteEnable, linkDownHotRst;

  int total = 0, fails = 0, fundCnt = 0, hotCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sw_reset_ctrl #(.DELAY_CYCLES(D)) uut (
    .clk(clk), .porRstN(porRstN), .hotRstIn(hotRstIn), .rstHaltPin(rstHaltPin),
    .linkDownEvt(linkDownEvt), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .ack(ack), .fundRstPulse(fundRstPulse), .hotRstPulse(hotRstPulse),
    .phyRetrainReq(phyRetrainReq), .coreHoldReset(coreHoldReset),
    .rwlWriteEnable(rwlWriteEnable), .pwrBudgetWriteEnable(pwrBudgetWriteEnable),
    .linkDownHotRst(linkDownHotRst)
  );

  always @(posedge clk) begin
    if (fundRstPulse) fundCnt++;
    if (hotRstPulse) hotCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input logic expAck);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R1 write ack", {31'd0, ack}, {31'd0, expAck});
  endtask

  task automatic busRead(output logic [31:0] d);
    @(negedge clk);
    addr = REG; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R1 read ack", {31'd0, ack}, 32'd1);
    d = rdData;
  endtask

  task automatic doPor(input logic pin);
    @(negedge clk);
    porRstN = 1'b0; rstHaltPin = pin;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
  endtask

  task automatic testResetState();
    logic [31:0] v;
    chk("R6 rdData idle", rdData, 32'd0);
    chk("R8 rwlWriteEnable after reset", {31'd0, rwlWriteEnable}, 32'd1);
    chk("R7 no hold with pin low", {31'd0, coreHoldReset}, 32'd0);
    busRead(v);
    chk("R6 reset value", v, 32'h08);
  endtask

  task automatic testFund();
    logic [31:0] v;
    int early = 0;
    busWrite(REG, 32'h09, 1'b1);
    early += fundRstPulse;
    repeat (D - 1) begin
      @(negedge clk);
      early += fundRstPulse;
    end
    chk("R3 no early fund pulse", early, 0);
    @(negedge clk);
    chk("R3 fund pulse on time", {31'd0, fundRstPulse}, 32'd1);
    @(negedge clk);
    chk("R3 fund pulse one cycle", {31'd0, fundRstPulse}, 32'd0);
    busRead(v);
    chk("R2 trigger reads zero", v, 32'h08);
  endtask

  task automatic testHot();
    int early = 0;
    busWrite(REG, 32'h0A, 1'b1);
    repeat (D - 1) begin
      @(negedge clk);
      early += hotRstPulse;
    end
    chk("R4 no early hot pulse", early, 0);
    @(negedge clk);
    chk("R4 hot pulse", {31'd0, hotRstPulse}, 32'd1);
    chk("R4 retrain with hot", {31'd0, phyRetrainReq}, 32'd1);
    @(negedge clk);
    chk("R4 retrain one cycle", {31'd0, phyRetrainReq}, 32'd0);
  endtask

  task automatic testPriority();
    int f0, h0;
    f0 = fundCnt; h0 = hotCnt;
    busWrite(REG, 32'h0A, 1'b1);
    repeat (3) @(negedge clk);
    busWrite(REG, 32'h09, 1'b1);
    busWrite(REG, 32'h0A, 1'b1);
    repeat (D + 4) @(negedge clk);
    chk("R5 fund replaces hot", fundCnt - f0, 1);
    chk("R5 hot dropped", hotCnt - h0, 0);
    f0 = fundCnt; h0 = hotCnt;
    busWrite(REG, 32'h0B, 1'b1);
    repeat (D + 4) @(negedge clk);
    chk("R5 both bits count as fund", fundCnt - f0, 1);
    chk("R5 both bits no hot", hotCnt - h0, 0);
  endtask

  task automatic testLock();
    logic [31:0] v;
    busWrite(REG, 32'h00, 1'b1);
    chk("R8 locked qualifier", {31'd0, rwlWriteEnable}, 32'd0);
    busWrite(REG, 32'h10, 1'b1);
    busRead(v);
    chk("R8 bit4 held while locked", v, 32'h00);
    chk("R9 pwr qualifier low", {31'd0, pwrBudgetWriteEnable}, 32'd0);
    busWrite(REG, 32'h08, 1'b1);
    busWrite(REG, 32'h18, 1'b1);
    busRead(v);
    chk("R8 bit4 written when unlocked", v, 32'h18);
    chk("R9 pwr qualifier high", {31'd0, pwrBudgetWriteEnable}, 32'd1);
  endtask

  task automatic testHotIn();
    logic [31:0] v;
    busWrite(REG, 32'h34, 1'b1);
    busRead(v);
    chk("R8 relock with bit4 kept", v, 32'h34);
    @(negedge clk); hotRstIn = 1'b1;
    @(negedge clk); hotRstIn = 1'b0;
    busRead(v);
    chk("R10 unlock forced, sticky kept", v, 32'h3C);
  endtask

  task automatic testLinkDown();
    @(negedge clk); linkDownEvt = 1'b1;
    #1 chk("R11 masked link-down", {31'd0, linkDownHotRst}, 32'd0);
    busWrite(REG, 32'h08, 1'b1);
    chk("R11 unmasked link-down", {31'd0, linkDownHotRst}, 32'd1);
    @(negedge clk); linkDownEvt = 1'b0;
    #1 chk("R11 follows event low", {31'd0, linkDownHotRst}, 32'd0);
  endtask

  task automatic testDecode();
    logic [31:0] v;
    busWrite(REG, 32'hFFFF_FFC8, 1'b1);
    busRead(v);
    chk("R2 reserved bits ignored", v, 32'h08);
    busWrite(12'h400, 32'h31, 1'b0);
    busRead(v);
    chk("R1 other address ignored", v, 32'h08);
  endtask

  task automatic testHalt();
    logic [31:0] v;
    busWrite(REG, 32'h38, 1'b1);
    doPor(1'b1);
    #1 chk("R7 hold from pin", {31'd0, coreHoldReset}, 32'd1);
    busRead(v);
    chk("R6 por restores with halt", v, 32'h0C);
    busWrite(REG, 32'h08, 1'b1);
    chk("R7 hold released", {31'd0, coreHoldReset}, 32'd0);
    busWrite(REG, 32'h0C, 1'b1);
    busRead(v);
    chk("R7 halt bit stored", v, 32'h0C);
    chk("R7 hold not re-raised", {31'd0, coreHoldReset}, 32'd0);
    rstHaltPin = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    testResetState();
    testFund();
    testHot();
    testPriority();
    testLock();
    testHotIn();
    testLinkDown();
    testDecode();
    testHalt();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule